// File: doc/BRIEF.md
# Dual-Clock Lane-Masked Word Memory

This block is a simple dual-port memory with one write port and one read port, each on its own clock and each gated by its own clock enable. A stored word is 20 bits wide and is made of two 10-bit lanes. Each lane holds eight data bits in its low positions and two spare bits above them. The spare bits are kept as ordinary storage, so a user can put parity in them or use them as extra data. The block never computes or checks anything on them.

A write changes only the lanes whose byte-enable bit is high, and only when the write enable and the write clock enable are both high. Every other lane keeps its old contents. The read port is registered, and its result appears one read-clock cycle after the request. A view input selects between two layouts. The full layout exposes all 20 bits. The plain layout is 16 bits wide and leaves out the spare positions, on both writes and reads.

Top module: `lram_dual_clock`

## Requirements
- R1: While `rd_rst_n` is low, `rd_data` is all zeros, and it stays zero until the first read after reset is released.
- R2: No lane is written unless `wr_ce` and `wr_en` are both high at the rising edge of `wr_clk`.
- R3: `wr_be[1]` selects word bits [19:10] and `wr_be[0]` selects bits [9:0]. The enables are active high, and a lane whose enable bit is low keeps its previous contents.
- R4: With `narrow_mode` low, a write stores the lane's spare bits (word bits [9:8] and [19:18]) exactly as given, and a full-view read returns them unchanged.
- R5: With `narrow_mode` high, `wr_data[7:0]` goes to word bits [7:0] and `wr_data[15:8]` goes to word bits [17:10]. The spare positions [9:8] and [19:18] of an enabled lane are left unchanged.
- R6: A read with `narrow_mode` high returns `{word[17:10], word[7:0]}` on `rd_data[15:0]`, and `rd_data[19:16]` is zero.
- R7: When `rd_ce` and `rd_en` are both high at a rising edge of `rd_clk`, `rd_data` shows the addressed word after that edge and not before it.
- R8: At a read-clock edge where `rd_ce` or `rd_en` is low, `rd_data` holds its value.
- R9: A read and a write to the same address at the same clock edge return the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_ce | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write address |
| wr_be | input | 2 | Active-high lane enables; bit 1 is the upper lane |
| wr_data | input | 20 | Write data (plain view uses bits [15:0]) |
| narrow_mode | input | 1 | 1 selects the 16-bit plain view, 0 the 20-bit full view |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read output |
| rd_ce | input | 1 | Read-side clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 9 | Read address |
| rd_data | output | 20 | Registered read data |

## Verification
The assertions assume that `narrow_mode` is stable around each read edge, so that the plain-view result can be tied to the request that was made. They also assume that the write-side checks only matter once reset has been released. The stimulus drives every input on the falling clock edge and holds it through the next rising edge, which keeps the mode, addresses and enables stable there. The bench runs both ports from one clock, so a read and a write to the same address always happen at the same edge and the old-data result is well defined. Every address is filled with a known full-width word before it is read, so no check depends on uninitialised storage.

// File: rtl/lram_pkg.sv
package lram_pkg;
  typedef enum logic {
    VIEW_FULL  = 1'b0,
    VIEW_PLAIN = 1'b1
  } view_e;

  function automatic int lane_lsb(input int lane, input int lane_w);
    return lane * lane_w;
  endfunction
endpackage

// File: rtl/lram_lane_store.sv
module lram_lane_store #(
  parameter int DEPTH   = 512,
  parameter int DATA_W  = 8,
  parameter int SPARE_W = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANE_W = DATA_W + SPARE_W
) (
  input  logic              wr_clk,
  input  logic              wr_ce,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_keep_spare,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_bits,
  input  logic [SPARE_W-1:0] wr_spare,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_hit,
  output logic [LANE_W-1:0] rd_lane
);
  logic [DATA_W-1:0]  data_arr  [DEPTH];
  logic [SPARE_W-1:0] spare_arr [DEPTH];

  assign wr_hit = wr_ce & wr_en & wr_sel;

  always_ff @(posedge wr_clk) begin
    if (wr_hit) begin
      data_arr[wr_addr] <= wr_bits;
      if (!wr_keep_spare) begin
        spare_arr[wr_addr] <= wr_spare;
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_lane <= '0;
    end else if (rd_fire) begin
      rd_lane <= {spare_arr[rd_addr], data_arr[rd_addr]};
    end
  end
endmodule

// File: rtl/lram_rd_format.sv
module lram_rd_format #(
  parameter int LANES   = 2,
  parameter int DATA_W  = 8,
  parameter int SPARE_W = 2,
  localparam int LANE_W = DATA_W + SPARE_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] lanes_q,
  input  logic              plain_q,
  output logic [WORD_W-1:0] rd_data
);
  function automatic logic [WORD_W-1:0] squeeze(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] res;
    res = '0;
    for (int l = 0; l < LANES; l++) begin
      res[l*DATA_W +: DATA_W] = w[lram_pkg::lane_lsb(l, LANE_W) +: DATA_W];
    end
    return res;
  endfunction

  assign rd_data = plain_q ? squeeze(lanes_q) : lanes_q;
endmodule

// File: rtl/lram_dual_clock.sv
module lram_dual_clock #(
  parameter int DEPTH        = 512,
  parameter int LANES        = 2,
  parameter int LANE_DATA_W  = 8,
  parameter int LANE_SPARE_W = 2,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int LANE_W      = LANE_DATA_W + LANE_SPARE_W,
  localparam int WORD_W      = LANES * LANE_W
) (
  input  logic              wr_clk,
  input  logic              wr_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              narrow_mode,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_ce,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  import lram_pkg::*;

  view_e             view_now;
  logic              plain_now;
  logic              plain_q;
  logic              rd_fire;
  logic [LANES-1:0]  wr_lane_hit;
  logic [WORD_W-1:0] lanes_q;

  assign view_now  = view_e'(narrow_mode);
  assign plain_now = (view_now == VIEW_PLAIN);
  assign rd_fire   = rd_ce & rd_en;

  function automatic logic [LANE_DATA_W-1:0] lane_bits(
    input logic [WORD_W-1:0] d, input logic plain, input int lane);
    if (plain) return d[lane_lsb(lane, LANE_DATA_W) +: LANE_DATA_W];
    return d[lane_lsb(lane, LANE_W) +: LANE_DATA_W];
  endfunction

  function automatic logic [LANE_SPARE_W-1:0] lane_spare(
    input logic [WORD_W-1:0] d, input int lane);
    return d[lane_lsb(lane, LANE_W) + LANE_DATA_W +: LANE_SPARE_W];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lram_lane_store #(
      .DEPTH  (DEPTH),
      .DATA_W (LANE_DATA_W),
      .SPARE_W(LANE_SPARE_W)
    ) store_i (
      .wr_clk       (wr_clk),
      .wr_ce        (wr_ce),
      .wr_en        (wr_en),
      .wr_sel       (wr_be[l]),
      .wr_keep_spare(plain_now),
      .wr_addr      (wr_addr),
      .wr_bits      (lane_bits(wr_data, plain_now, l)),
      .wr_spare     (lane_spare(wr_data, l)),
      .rd_clk       (rd_clk),
      .rd_rst_n     (rd_rst_n),
      .rd_fire      (rd_fire),
      .rd_addr      (rd_addr),
      .wr_hit       (wr_lane_hit[l]),
      .rd_lane      (lanes_q[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      plain_q <= 1'b0;
    end else if (rd_fire) begin
      plain_q <= plain_now;
    end
  end

  lram_rd_format #(
    .LANES  (LANES),
    .DATA_W (LANE_DATA_W),
    .SPARE_W(LANE_SPARE_W)
  ) fmt_i (
    .lanes_q(lanes_q),
    .plain_q(plain_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/lram_dual_clock_chk.sv
module lram_dual_clock_chk #(
  parameter int LANES   = 2,
  parameter int NARROW_W = 16,
  parameter int WORD_W  = 20
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              wr_ce,
  input logic              wr_en,
  input logic [LANES-1:0]  wr_be,
  input logic [LANES-1:0]  wr_lane_hit,
  input logic              rd_fire,
  input logic              narrow_mode,
  input logic [WORD_W-1:0] rd_data
);
  // R8
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_fire |=> $stable(rd_data));

  // R6
  plain_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_fire && narrow_mode) |=> (rd_data[WORD_W-1:NARROW_W] == '0));

  // R2
  no_write_chk: assert property (@(posedge wr_clk) disable iff (!rd_rst_n)
    !(wr_en && wr_ce) |-> (wr_lane_hit == '0));

  // R3
  lane_select_chk: assert property (@(posedge wr_clk) disable iff (!rd_rst_n)
    wr_en |-> ((wr_lane_hit & ~wr_be) == '0));
endmodule

bind lram_dual_clock lram_dual_clock_chk #(
  .LANES   (LANES),
  .NARROW_W(LANES * LANE_DATA_W),
  .WORD_W  (WORD_W)
) chk_i (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .rd_rst_n   (rd_rst_n),
  .wr_ce      (wr_ce),
  .wr_en      (wr_en),
  .wr_be      (wr_be),
  .wr_lane_hit(wr_lane_hit),
  .rd_fire    (rd_fire),
  .narrow_mode(narrow_mode),
  .rd_data    (rd_data)
);

// File: tb/lram_dual_clock_tb_top.sv
`timescale 1ns/1ps
module lram_dual_clock_tb_top;
  localparam int AW = 9;
  localparam int WW = 20;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic wr_ce = 1'b1, wr_en = 1'b0, narrow_mode = 1'b0;
  logic rd_rst_n = 1'b0, rd_ce = 1'b1, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [1:0] wr_be = 2'b11;
  logic [WW-1:0] wr_data = '0;
  logic [WW-1:0] rd_data;

  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [WW-1:0] model [512];

  always #2 clk = ~clk;

  lram_dual_clock dut_i (
    .wr_clk(clk), .wr_ce(wr_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .narrow_mode(narrow_mode),
    .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_ce(rd_ce), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // entry = {addr[8:0], be[1:0], plain, data[19:0]}
  localparam logic [31:0] VEC [NV] = '{
    {9'd1, 2'b11, 1'b0, 20'hFFC03},
    {9'd2, 2'b01, 1'b0, 20'h12345},
    {9'd3, 2'b10, 1'b0, 20'hABCDE},
    {9'd4, 2'b11, 1'b1, 20'h0BEEF},
    {9'd5, 2'b01, 1'b1, 20'h0CAFE},
    {9'd6, 2'b10, 1'b1, 20'h0F00D},
    {9'd7, 2'b11, 1'b0, 20'hC0300},
    {9'd8, 2'b00, 1'b0, 20'hFFFFF}
  };

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] plain_view(input logic [WW-1:0] w);
    return {4'h0, w[17:10], w[7:0]};
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [1:0] be,
                             input logic pl, input logic [WW-1:0] d);
    if (be[0]) begin
      if (pl) model[a][7:0] = d[7:0]; else model[a][9:0] = d[9:0];
    end
    if (be[1]) begin
      if (pl) model[a][17:10] = d[15:8]; else model[a][19:10] = d[19:10];
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [1:0] be,
                          input logic pl, input logic [WW-1:0] d);
    @(negedge clk);
    wr_addr = a; wr_be = be; narrow_mode = pl; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, be, pl, d);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic pl);
    @(negedge clk);
    rd_addr = a; narrow_mode = pl; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", rd_data, '0);
    rd_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 zero after release", rd_data, '0);

    for (int a = 0; a < 16; a++) begin
      do_write(AW'(a), 2'b11, 1'b0, 20'h5A5A5 ^ WW'(a * 20'h01111));
    end

    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [1:0] be;
      logic pl;
      logic [WW-1:0] d;
      {a, be, pl, d} = VEC[i];
      do_write(a, be, pl, d);
      do_read(a, pl);
      if (pl) check("R5 R6 plain write and read", rd_data, plain_view(model[a]));
      else if (be != 2'b11) check("R3 lane masking", rd_data, model[a]);
      else check("R4 spare bits stored", rd_data, model[a]);
      do_read(a, 1'b0);
      check(pl ? "R5 spare positions kept" : "R3 R4 full readback", rd_data, model[a]);
    end

    // R2: write enable low
    @(negedge clk);
    wr_addr = 9'd9; wr_be = 2'b11; narrow_mode = 1'b0; wr_data = 20'h00000;
    wr_en = 1'b0;
    @(posedge clk);
    do_read(9'd9, 1'b0);
    check("R2 wr_en low ignored", rd_data, model[9]);

    // R2: clock enable low
    @(negedge clk);
    wr_addr = 9'd10; wr_data = 20'h00001; wr_en = 1'b1; wr_ce = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_ce = 1'b1;
    do_read(9'd10, 1'b0);
    check("R2 wr_ce low ignored", rd_data, model[10]);

    // R7: one-cycle latency
    do_read(9'd1, 1'b0);
    @(negedge clk);
    rd_addr = 9'd2; rd_en = 1'b1;
    #1;
    check("R7 not before edge", rd_data, model[1]);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 after edge", rd_data, model[2]);

    // R8: hold with rd_ce low, then with rd_en low
    @(negedge clk);
    rd_addr = 9'd3; rd_en = 1'b1; rd_ce = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 rd_ce low holds", rd_data, model[2]);
    rd_ce = 1'b1; rd_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 rd_en low holds", rd_data, model[2]);

    // R9: same-edge read and write of one address
    @(negedge clk);
    wr_addr = 9'd11; wr_be = 2'b11; narrow_mode = 1'b0; wr_data = 20'h3C3C3; wr_en = 1'b1;
    rd_addr = 9'd11; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 old data returned", rd_data, model[11]);
    model_write(9'd11, 2'b11, 1'b0, 20'h3C3C3);
    do_read(9'd11, 1'b0);
    check("R9 new data afterwards", rd_data, model[11]);

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rd_rst_n = 1'b0;
    #1;
    check("R1 async clear", rd_data, '0);
    @(negedge clk);
    rd_rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule